// File: doc/BRIEF.md
# Programmable Prescaled Overflow Timer

An 8-bit timer peripheral that counts CPU cycles. Each cycle that the processor finishes is reported by a one-clock advance strobe. While the timer runs, a 10-bit down-counting prescaler consumes these strobes. Each time the prescaler expires, it reloads itself with a period chosen by a two-bit rate select, and the 8-bit count register advances by one. The rate select encoding is not monotonic.

When the count register carries out of its top bit, it does not wrap to zero. It takes the value held in a programmable modulo register, and in the same clock edge the block emits a one-clock timer interrupt request. Software reaches the count, modulo and control registers through a byte-wide port with a 2-bit address. Writes take effect at the clock edge. Reads are combinational.

Run control is a two-state machine. ST_HALT and ST_RUN hold the enable bit of the control register. A control write with bit 2 set moves the machine from ST_HALT to ST_RUN, and a control write with bit 2 clear moves it from ST_RUN to ST_HALT. Any other cycle keeps the current state. In ST_HALT, strobes are ignored and the prescaler keeps its remaining count.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, address 0 (count) reads 0x00, address 1 (modulo) reads 0x00 and address 2 (control) reads 0xF8. The prescaler is loaded for a 1024-strobe period, so the first increment after enabling comes on the 1024th strobe.
- R2: Address 0 reads and writes the count, and address 1 reads and writes the modulo value. Address 2 stores bits 2:0 and reads bits 7:3 as ones. Address 3 always reads 0xFF, and a write to it changes no other register.
- R3: While control bit 2 is 0 (ST_HALT), strobes do not change the count.
- R4: Control bits 1:0 select how many strobes make one increment: 00 selects 1024, 01 selects 16, 10 selects 64 and 11 selects 256. The count advances on the last strobe of the period, never earlier.
- R5: Halting keeps the remaining prescaler count. After re-enabling, counting resumes from where it stopped.
- R6: An increment from 0xFF loads the modulo value instead of 0x00. If the modulo register is written in the same cycle, the value held before that edge is the one loaded.
- R7: The interrupt output is high for exactly one clock. It rises in the same edge that loads the modulo value.
- R8: A count write in the same cycle as an overflow wins over the modulo load, and no interrupt pulse is produced.
- R9: Changing the rate select does not restart the current countdown. The new period first applies at the next prescaler reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One-cycle advance strobe, one per CPU cycle |
| bus_addr_i | input | 2 | Register address: 0 count, 1 modulo, 2 control, 3 reserved |
| bus_wr_i | input | 1 | Write enable for the addressed register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | One-clock timer overflow interrupt request |

## Verification
Register writes and strobes take effect at the rising edge where they are sampled. The count, the read data and irq_o therefore show the result at the falling edge that follows. Reads are combinational and are sampled 1 ns after the address changes, with no strobe active. Each scenario drives its inputs at falling edges and then checks the count on the exact strobe that finishes a period and on the strobe just before it. The interrupt is checked at the falling edge right after the overflow strobe and again one clock later, to confirm the pulse lasts one clock. Every scenario starts from a reset and a full 1024-strobe first period, so the prescaler phase is known.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
    localparam int DATA_W = 8;
    localparam int PRE_W  = 10;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        ADDR_COUNT  = 2'd0,
        ADDR_MODULO = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_RSVD   = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Number of strobes per increment, minus one, for a rate select code.
    function automatic logic [PRE_W-1:0] reload_value(input logic [SEL_W-1:0] sel);
        logic [PRE_W:0] period;
        unique case (sel)
            2'b00:   period = (PRE_W+1)'(1024);
            2'b01:   period = (PRE_W+1)'(16);
            2'b10:   period = (PRE_W+1)'(64);
            default: period = (PRE_W+1)'(256);
        endcase
        return PRE_W'(period - (PRE_W+1)'(1));
    endfunction
endpackage

// File: rtl/ptm_ctrl.sv
module ptm_ctrl
    import ptm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SEL_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_ctrl_i,
    input  logic [DW-1:0] wdata_i,
    output logic          run_o,
    output logic [SW-1:0] sel_o,
    output logic [DW-1:0] ctrl_rd_o
);
    localparam int EN_BIT = SW;
    localparam int PAD_W  = DW - SW - 1;

    run_state_e state_q, state_d;
    logic [SW-1:0] sel_q;

    // Next-state selection: only a control write moves the machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (wr_ctrl_i && wdata_i[EN_BIT])  state_d = ST_RUN;
            ST_RUN:  if (wr_ctrl_i && !wdata_i[EN_BIT]) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_HALT;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_ctrl_i) sel_q <= wdata_i[SW-1:0];
        end
    end

    // Outputs.
    always_comb begin
        run_o     = (state_q == ST_RUN);
        sel_o     = sel_q;
        ctrl_rd_o = {{PAD_W{1'b1}}, run_o, sel_q};
    end
endmodule

// File: rtl/ptm_prescaler.sv
module ptm_prescaler
    import ptm_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          step_i,
    input  logic [SW-1:0] sel_i,
    output logic          tick_o,
    output logic [PW-1:0] pre_o
);
    logic [PW-1:0] pre_q;
    logic          expire;

    assign expire = (pre_q == '0);
    assign tick_o = run_i && step_i && expire;
    assign pre_o  = pre_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q <= PW'(reload_value('0));
        end else if (run_i && step_i) begin
            if (expire) pre_q <= PW'(reload_value(sel_i));
            else        pre_q <= pre_q - PW'(1);
        end
    end
endmodule

// File: rtl/ptm_count_unit.sv
module ptm_count_unit
    import ptm_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          wr_cnt_i,
    input  logic          wr_mod_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] mod_o,
    output logic          irq_o
);
    logic [DW-1:0] cnt_q, mod_q;
    logic [DW:0]   sum;
    logic          carry;
    logic          irq_q;

    assign sum   = {1'b0, cnt_q} + (DW+1)'(1);
    assign carry = sum[DW];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            mod_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_mod_i) mod_q <= wdata_i;
            if (wr_cnt_i) begin
                cnt_q <= wdata_i;
            end else if (tick_i) begin
                if (carry) begin
                    cnt_q <= mod_q;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= sum[DW-1:0];
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign mod_o = mod_q;
    assign irq_o = irq_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import ptm_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       step_i,
    input  logic [1:0] bus_addr_i,
    input  logic       bus_wr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       irq_o
);
    logic              wr_cnt, wr_mod, wr_ctrl;
    logic              run_en, tick;
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre_q;
    logic [DATA_W-1:0] cnt_q, mod_q, ctrl_rd;
    reg_addr_e         addr;

    assign addr    = reg_addr_e'(bus_addr_i);
    assign wr_cnt  = bus_wr_i && (addr == ADDR_COUNT);
    assign wr_mod  = bus_wr_i && (addr == ADDR_MODULO);
    assign wr_ctrl = bus_wr_i && (addr == ADDR_CTRL);

    ptm_ctrl #(.DW(DATA_W), .SW(SEL_W)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_ctrl_i (wr_ctrl),
        .wdata_i   (bus_wdata_i),
        .run_o     (run_en),
        .sel_o     (sel),
        .ctrl_rd_o (ctrl_rd)
    );

    ptm_prescaler #(.PW(PRE_W), .SW(SEL_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_en),
        .step_i (step_i),
        .sel_i  (sel),
        .tick_o (tick),
        .pre_o  (pre_q)
    );

    ptm_count_unit #(.DW(DATA_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .wr_cnt_i (wr_cnt),
        .wr_mod_i (wr_mod),
        .wdata_i  (bus_wdata_i),
        .cnt_o    (cnt_q),
        .mod_o    (mod_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        unique case (addr)
            ADDR_COUNT:  bus_rdata_o = cnt_q;
            ADDR_MODULO: bus_rdata_o = mod_q;
            ADDR_CTRL:   bus_rdata_o = ctrl_rd;
            default:     bus_rdata_o = '1;
        endcase
    end
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
    parameter int DW = 8,
    parameter int PW = 10
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          step_i,
    input logic          wr_cnt,
    input logic          run,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] mod,
    input logic [PW-1:0] pre,
    input logic          irq
);
    // R3: a halted timer leaves count and prescaler untouched
    assert_halt_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !wr_cnt) |=> $stable(cnt));
    assert_halt_prescaler_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |=> $stable(pre));
    // R4: without a strobe the count only changes by a write
    assert_no_strobe_no_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !wr_cnt) |=> $stable(cnt));
    // R6: the pulse comes with the count holding the earlier modulo value
    assert_reload_modulo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq) |-> (cnt == $past(mod)));
    // R7: one-clock pulse
    assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq |=> !irq);
    // R8: a pulse needs a running strobe with no count write
    assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq) |-> $past(run && step_i && !wr_cnt && cnt == '1));
endmodule

bind prescaled_timer ptm_checker #(.DW(ptm_pkg::DATA_W), .PW(ptm_pkg::PRE_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .wr_cnt (wr_cnt),
    .run    (run_en),
    .cnt    (cnt_q),
    .mod    (mod_q),
    .pre    (pre_q),
    .irq    (irq_o)
);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prescaled_timer u_prescaled_timer (
        .clk_i(clk), .rst_ni(rst_n), .step_i(step), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; step = 1'b0; wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); step = 1'b1;
        end
        @(negedge clk); step = 1'b0;
    endtask

    // Reset, enable with a rate, finish the 1024-strobe first period: count = 1.
    task automatic prime(input logic [1:0] sel);
        logic [7:0] d;
        do_reset();
        reg_wr(2'd2, {5'b0, 1'b1, sel});
        strobe(1024);
        reg_rd(2'd0, d);
        check("R9 first period", d, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        reg_rd(2'd0, d); check("R1 count", d, 8'h00);
        reg_rd(2'd1, d); check("R1 modulo", d, 8'h00);
        reg_rd(2'd2, d); check("R1 control", d, 8'hF8);
        check("R1 irq", irq, 0);
        reg_wr(2'd2, 8'h05);
        strobe(1023);
        reg_rd(2'd0, d); check("R1 before 1024", d, 8'h00);
        strobe(1);
        reg_rd(2'd0, d); check("R1 at 1024", d, 8'h01);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        do_reset();
        reg_wr(2'd1, 8'h5A); reg_rd(2'd1, d); check("R2 modulo rw", d, 8'h5A);
        reg_wr(2'd0, 8'hC3); reg_rd(2'd0, d); check("R2 count rw", d, 8'hC3);
        reg_wr(2'd2, 8'h02); reg_rd(2'd2, d); check("R2 control pad", d, 8'hFA);
        reg_wr(2'd2, 8'h07); reg_rd(2'd2, d); check("R2 control all", d, 8'hFF);
        reg_wr(2'd3, 8'h00); reg_rd(2'd3, d); check("R2 reserved", d, 8'hFF);
        reg_rd(2'd0, d); check("R2 reserved count", d, 8'hC3);
        reg_rd(2'd1, d); check("R2 reserved modulo", d, 8'h5A);
        reg_rd(2'd2, d); check("R2 reserved ctrl", d, 8'hFF);
    endtask

    task automatic t_halt();
        logic [7:0] d;
        prime(2'b01);
        reg_wr(2'd2, 8'h01);
        strobe(100);
        reg_rd(2'd0, d); check("R3 halted count", d, 8'h01);
    endtask

    task automatic t_rates();
        logic [7:0] d;
        int per;
        for (int s = 0; s < 4; s++) begin
            per = (s == 0) ? 1024 : (s == 1) ? 16 : (s == 2) ? 64 : 256;
            prime(2'(s));
            strobe(per - 1);
            reg_rd(2'd0, d); check("R4 period-1", d, 8'h01);
            strobe(1);
            reg_rd(2'd0, d); check("R4 period", d, 8'h02);
        end
    endtask

    task automatic t_resume();
        logic [7:0] d;
        prime(2'b01);
        strobe(10);
        reg_wr(2'd2, 8'h01);
        strobe(50);
        reg_wr(2'd2, 8'h05);
        strobe(5);
        reg_rd(2'd0, d); check("R5 residue", d, 8'h01);
        strobe(1);
        reg_rd(2'd0, d); check("R5 resumed", d, 8'h02);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        prime(2'b01);
        reg_wr(2'd1, 8'hA5);
        reg_wr(2'd0, 8'hFF);
        strobe(15);
        check("R7 no early irq", irq, 0);
        // overflow strobe with a simultaneous modulo write: old modulo loads
        @(negedge clk); step = 1'b1; addr = 2'd1; wdata = 8'h11; wr = 1'b1;
        @(negedge clk); step = 1'b0; wr = 1'b0;
        check("R7 irq high", irq, 1);
        @(negedge clk);
        check("R7 irq one clock", irq, 0);
        reg_rd(2'd0, d); check("R6 reload", d, 8'hA5);
        reg_rd(2'd1, d); check("R6 modulo written", d, 8'h11);
    endtask

    task automatic t_write_wins();
        logic [7:0] d;
        int seen = 0;
        prime(2'b01);
        reg_wr(2'd1, 8'h40);
        reg_wr(2'd0, 8'hFF);
        strobe(15);
        @(negedge clk); step = 1'b1; addr = 2'd0; wdata = 8'h33; wr = 1'b1;
        @(negedge clk); step = 1'b0; wr = 1'b0;
        if (irq) seen++;
        @(negedge clk);
        if (irq) seen++;
        check("R8 no irq", seen, 0);
        reg_rd(2'd0, d); check("R8 write wins", d, 8'h33);
    endtask

    task automatic t_rate_change();
        logic [7:0] d;
        prime(2'b01);
        strobe(5);
        reg_wr(2'd2, 8'h07);
        strobe(10);
        reg_rd(2'd0, d); check("R9 old countdown", d, 8'h01);
        strobe(1);
        reg_rd(2'd0, d); check("R9 old period ends", d, 8'h02);
        strobe(255);
        reg_rd(2'd0, d); check("R9 new period-1", d, 8'h02);
        strobe(1);
        reg_rd(2'd0, d); check("R9 new period", d, 8'h03);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_halt();
        t_rates();
        t_resume();
        t_overflow();
        t_write_wins();
        t_rate_change();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule